// File: doc/BRIEF.md
# Rename Buffer with Result Forwarding

This block keeps the results of one register class between the moment an execution unit finishes and the moment that result becomes architectural state. A dispatcher allocates an entry for each instruction that will write a register. The block records which entry is now the newest producer of that register. When the unit finishes, its data goes into that entry, not into the register file. In the same cycle the data is driven on a forwarding bus and handed to any read port whose register is produced by that entry. A later write-back step copies the entry into the architectural register file and frees the entry. A flush discards every entry that has not been committed.

Several source-read ports, two by default, each take an architectural register number. Each port returns the newest value known for that register, or the tag of the entry that will produce it. An instruction can therefore pick up a result in the same cycle it is produced, without waiting for a register-file read.

Top module: `rnb_rename_buf`

## Requirements
- R1: After reset every entry is free, every architectural register reads as zero with ready high, `alloc_tag` shows entry 0, and `alloc_gnt` and `fwd_vld` are low.
- R2: An allocation request is granted in the same cycle with the lowest-numbered free entry on `alloc_tag`. While every entry is in use and no write-back frees one, `alloc_gnt` stays low.
- R3: A read of a register with no uncommitted producer returns the architectural value with ready high.
- R4: A read of a register whose newest producer has not finished returns ready low, with that entry's number on the port's tag field.
- R5: A read of a register whose newest producer finishes in the same cycle returns the finishing data with ready high, ahead of any older rename or architectural value.
- R6: A read of a register whose newest producer has finished returns that entry's value. When two entries target one register, the entry allocated last is the one consulted.
- R7: A write-back of a finished entry copies its value into the architectural register and frees the entry for the next cycle. Reads see the same value before and after the copy.
- R8: When a write-back and an allocation happen in the same cycle, the entry being written back counts as free, so the allocation may receive that same entry number.
- R9: A flush frees every entry and blocks allocation in that cycle; later reads return architectural values. A write-back in the flush cycle still commits.
- R10: Every read port resolves its own register independently of the others in the same cycle.
- R11: A finish aimed at a free or already finished entry is ignored, with `fwd_vld` low. A write-back aimed at an unfinished entry is ignored and leaves the entry in use.
- R12: An accepted finish drives `fwd_vld` high in that cycle, with the entry number, the destination register number and the data on the forwarding bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all uncommitted entries |
| alloc_req | input | 1 | Request a rename entry |
| alloc_areg | input | AW | Destination architectural register of the allocation |
| alloc_gnt | output | 1 | Allocation granted this cycle |
| alloc_tag | output | TW | Lowest free entry, the granted entry when alloc_gnt is high |
| fin_vld | input | 1 | Execution unit finishes this cycle |
| fin_tag | input | TW | Entry receiving the result |
| fin_data | input | WIDTH | Result data |
| wb_vld | input | 1 | Commit an entry this cycle |
| wb_tag | input | TW | Entry to commit |
| rd_areg | input | PORTS*AW | Register number per read port, port p in bits [p*AW +: AW] |
| rd_data | output | PORTS*WIDTH | Operand value per port |
| rd_ready | output | PORTS | Operand value valid per port |
| rd_tag | output | PORTS*TW | Producing entry when the operand is not ready |
| fwd_vld | output | 1 | Forwarding bus carries a result |
| fwd_tag | output | TW | Entry of the forwarded result |
| fwd_areg | output | AW | Destination register of the forwarded result |
| fwd_data | output | WIDTH | Forwarded data |

## Verification
The bench builds the block with its default parameters: eight entries, 32 registers of 32 bits and two read ports. With eight entries, filling the buffer takes only a few allocations, so the no-grant case and the reuse of an entry during write-back can be reached in a short directed run. With two ports, a forwarded read and a plain architectural read can be checked in the same cycle. A register with two live producers shows which entry a read consults. A flush is exercised while it coincides with a write-back and an allocation request.

// File: rtl/rnb_pkg.sv
package rnb_pkg;
   localparam int unsigned RNB_DEF_ENTRIES = 8;
   localparam int unsigned RNB_DEF_REGS    = 32;
   localparam int unsigned RNB_DEF_WIDTH   = 32;
   localparam int unsigned RNB_DEF_PORTS   = 2;

   // where a read port found its operand
   typedef enum logic [1:0] {
      SRC_ARCH  = 2'd0,
      SRC_ENTRY = 2'd1,
      SRC_FWD   = 2'd2,
      SRC_WAIT  = 2'd3
   } rnb_src_e;
endpackage

// File: rtl/rnb_free_list.sv
module rnb_free_list #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned TW      = 3
) (
   input  logic [ENTRIES-1:0] busy,
   input  logic [ENTRIES-1:0] wb_free,
   input  logic               alloc_req,
   input  logic               flush,
   output logic               alloc_gnt,
   output logic [TW-1:0]      alloc_tag,
   output logic [ENTRIES-1:0] alloc_oh
);
   logic [ENTRIES-1:0] avail;
   logic               found;

   // an entry committed this cycle is already free for a new owner
   assign avail = ~busy | wb_free;

   always_comb begin
      found     = 1'b0;
      alloc_tag = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (avail[i]) begin
            found     = 1'b1;
            alloc_tag = TW'(i);
         end
      end
   end

   assign alloc_gnt = alloc_req & found & ~flush;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         alloc_oh[i] = alloc_gnt && (alloc_tag == TW'(i));
      end
   end
endmodule

// File: rtl/rnb_entry_array.sv
module rnb_entry_array #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned AW      = 5,
   parameter int unsigned TW      = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic [ENTRIES-1:0]         alloc_oh,
   input  logic [AW-1:0]              alloc_areg,
   input  logic                       fin_vld,
   input  logic [TW-1:0]              fin_tag,
   input  logic [WIDTH-1:0]           fin_data,
   input  logic                       wb_vld,
   input  logic [TW-1:0]              wb_tag,
   output logic [ENTRIES-1:0]         busy,
   output logic [ENTRIES-1:0]         done,
   output logic [ENTRIES*WIDTH-1:0]   ent_data,
   output logic                       fin_ok,
   output logic [AW-1:0]              fin_areg,
   output logic                       wb_ok,
   output logic [AW-1:0]              wb_areg,
   output logic [WIDTH-1:0]           wb_data,
   output logic [ENTRIES-1:0]         wb_free
);
   logic [AW-1:0]    areg_q [ENTRIES];
   logic [WIDTH-1:0] data_q [ENTRIES];

   assign fin_ok   = fin_vld & busy[fin_tag] & ~done[fin_tag];
   assign wb_ok    = wb_vld & busy[wb_tag] & done[wb_tag];
   assign fin_areg = areg_q[fin_tag];
   assign wb_areg  = areg_q[wb_tag];
   assign wb_data  = data_q[wb_tag];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic hit_fin;
      logic hit_wb;

      assign hit_fin    = fin_ok && (fin_tag == TW'(e));
      assign hit_wb     = wb_ok && (wb_tag == TW'(e));
      assign wb_free[e] = hit_wb;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy[e] <= 1'b0;
            done[e] <= 1'b0;
         end else if (flush) begin
            busy[e] <= 1'b0;
            done[e] <= 1'b0;
         end else if (alloc_oh[e]) begin
            busy[e] <= 1'b1;
            done[e] <= 1'b0;
         end else if (hit_wb) begin
            busy[e] <= 1'b0;
            done[e] <= 1'b0;
         end else if (hit_fin) begin
            done[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            areg_q[e] <= '0;
         end else if (alloc_oh[e]) begin
            areg_q[e] <= alloc_areg;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_fin) begin
            data_q[e] <= fin_data;
         end
      end

      assign ent_data[e*WIDTH +: WIDTH] = data_q[e];
   end
endmodule

// File: rtl/rnb_map_table.sv
module rnb_map_table #(
   parameter int unsigned REGS = 32,
   parameter int unsigned AW   = 5,
   parameter int unsigned TW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               alloc_gnt,
   input  logic [AW-1:0]      alloc_areg,
   input  logic [TW-1:0]      alloc_tag,
   input  logic               wb_ok,
   input  logic [AW-1:0]      wb_areg,
   input  logic [TW-1:0]      wb_tag,
   output logic [REGS-1:0]    map_vld,
   output logic [REGS*TW-1:0] map_tag
);
   for (genvar r = 0; r < REGS; r++) begin : g_reg
      logic [TW-1:0] tag_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            map_vld[r] <= 1'b0;
            tag_q      <= '0;
         end else if (flush) begin
            map_vld[r] <= 1'b0;
         end else if (alloc_gnt && (alloc_areg == AW'(r))) begin
            map_vld[r] <= 1'b1;
            tag_q      <= alloc_tag;
         end else if (wb_ok && (wb_areg == AW'(r)) && (tag_q == wb_tag)) begin
            // the newest producer committed: the register file is current
            map_vld[r] <= 1'b0;
         end
      end

      assign map_tag[r*TW +: TW] = tag_q;
   end
endmodule

// File: rtl/rnb_read_port.sv
module rnb_read_port
   import rnb_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned REGS    = 32,
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned AW      = 5,
   parameter int unsigned TW      = 3
) (
   input  logic [AW-1:0]              areg,
   input  logic [REGS-1:0]            map_vld,
   input  logic [REGS*TW-1:0]         map_tag,
   input  logic [ENTRIES-1:0]         done,
   input  logic [ENTRIES*WIDTH-1:0]   ent_data,
   input  logic [REGS*WIDTH-1:0]      arch_data,
   input  logic                       fin_ok,
   input  logic [TW-1:0]              fin_tag,
   input  logic [WIDTH-1:0]           fin_data,
   output logic [WIDTH-1:0]           rd_data,
   output logic                       rd_ready,
   output logic [TW-1:0]              rd_tag
);
   logic [TW-1:0] prod;
   rnb_src_e      src;

   assign prod = map_tag[int'(areg)*TW +: TW];

   always_comb begin
      if (!map_vld[areg])                   src = SRC_ARCH;
      else if (fin_ok && (fin_tag == prod)) src = SRC_FWD;
      else if (done[prod])                  src = SRC_ENTRY;
      else                                  src = SRC_WAIT;
   end

   always_comb begin
      unique case (src)
         SRC_ARCH:  rd_data = arch_data[int'(areg)*WIDTH +: WIDTH];
         SRC_FWD:   rd_data = fin_data;
         SRC_ENTRY: rd_data = ent_data[int'(prod)*WIDTH +: WIDTH];
         default:   rd_data = '0;
      endcase
   end

   assign rd_ready = (src != SRC_WAIT);
   assign rd_tag   = map_vld[areg] ? prod : '0;
endmodule

// File: rtl/rnb_rename_buf.sv
module rnb_rename_buf
   import rnb_pkg::*;
#(
   parameter int unsigned ENTRIES = RNB_DEF_ENTRIES,
   parameter int unsigned REGS    = RNB_DEF_REGS,
   parameter int unsigned WIDTH   = RNB_DEF_WIDTH,
   parameter int unsigned PORTS   = RNB_DEF_PORTS,
   localparam int unsigned TW     = $clog2(ENTRIES),
   localparam int unsigned AW     = $clog2(REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  alloc_req,
   input  logic [AW-1:0]         alloc_areg,
   output logic                  alloc_gnt,
   output logic [TW-1:0]         alloc_tag,
   input  logic                  fin_vld,
   input  logic [TW-1:0]         fin_tag,
   input  logic [WIDTH-1:0]      fin_data,
   input  logic                  wb_vld,
   input  logic [TW-1:0]         wb_tag,
   input  logic [PORTS*AW-1:0]   rd_areg,
   output logic [PORTS*WIDTH-1:0] rd_data,
   output logic [PORTS-1:0]      rd_ready,
   output logic [PORTS*TW-1:0]   rd_tag,
   output logic                  fwd_vld,
   output logic [TW-1:0]         fwd_tag,
   output logic [AW-1:0]         fwd_areg,
   output logic [WIDTH-1:0]      fwd_data
);
   // elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << TW) != ENTRIES) begin : g_bad_entries
      $error("rnb_rename_buf: ENTRIES must be a power of two, at least 2");
   end
   if (REGS < 2 || (1 << AW) != REGS) begin : g_bad_regs
      $error("rnb_rename_buf: REGS must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rnb_rename_buf: WIDTH must be at least 1");
   end
   if (PORTS < 1) begin : g_bad_ports
      $error("rnb_rename_buf: PORTS must be at least 1");
   end

   logic [ENTRIES-1:0]       ent_busy;
   logic [ENTRIES-1:0]       ent_done;
   logic [ENTRIES-1:0]       ent_wb_free;
   logic [ENTRIES-1:0]       alloc_oh;
   logic [ENTRIES*WIDTH-1:0] ent_data;
   logic                     fin_ok;
   logic [AW-1:0]            fin_areg;
   logic                     wb_ok;
   logic [AW-1:0]            wb_areg;
   logic [WIDTH-1:0]         wb_data;
   logic [REGS-1:0]          map_vld;
   logic [REGS*TW-1:0]       map_tag;
   logic [REGS*WIDTH-1:0]    arch_data;
   logic [WIDTH-1:0]         arch_q [REGS];

   rnb_free_list #(
      .ENTRIES (ENTRIES),
      .TW      (TW)
   ) u_free (
      .busy      (ent_busy),
      .wb_free   (ent_wb_free),
      .alloc_req (alloc_req),
      .flush     (flush),
      .alloc_gnt (alloc_gnt),
      .alloc_tag (alloc_tag),
      .alloc_oh  (alloc_oh)
   );

   rnb_entry_array #(
      .ENTRIES (ENTRIES),
      .WIDTH   (WIDTH),
      .AW      (AW),
      .TW      (TW)
   ) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_oh   (alloc_oh),
      .alloc_areg (alloc_areg),
      .fin_vld    (fin_vld),
      .fin_tag    (fin_tag),
      .fin_data   (fin_data),
      .wb_vld     (wb_vld),
      .wb_tag     (wb_tag),
      .busy       (ent_busy),
      .done       (ent_done),
      .ent_data   (ent_data),
      .fin_ok     (fin_ok),
      .fin_areg   (fin_areg),
      .wb_ok      (wb_ok),
      .wb_areg    (wb_areg),
      .wb_data    (wb_data),
      .wb_free    (ent_wb_free)
   );

   rnb_map_table #(
      .REGS (REGS),
      .AW   (AW),
      .TW   (TW)
   ) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_gnt  (alloc_gnt),
      .alloc_areg (alloc_areg),
      .alloc_tag  (alloc_tag),
      .wb_ok      (wb_ok),
      .wb_areg    (wb_areg),
      .wb_tag     (wb_tag),
      .map_vld    (map_vld),
      .map_tag    (map_tag)
   );

   // architectural register file, written only by committing entries
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < REGS; r++) arch_q[r] <= '0;
      end else if (wb_ok) begin
         arch_q[wb_areg] <= wb_data;
      end
   end

   for (genvar r = 0; r < REGS; r++) begin : g_arch
      assign arch_data[r*WIDTH +: WIDTH] = arch_q[r];
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      rnb_read_port #(
         .ENTRIES (ENTRIES),
         .REGS    (REGS),
         .WIDTH   (WIDTH),
         .AW      (AW),
         .TW      (TW)
      ) u_rd (
         .areg      (rd_areg[p*AW +: AW]),
         .map_vld   (map_vld),
         .map_tag   (map_tag),
         .done      (ent_done),
         .ent_data  (ent_data),
         .arch_data (arch_data),
         .fin_ok    (fin_ok),
         .fin_tag   (fin_tag),
         .fin_data  (fin_data),
         .rd_data   (rd_data[p*WIDTH +: WIDTH]),
         .rd_ready  (rd_ready[p]),
         .rd_tag    (rd_tag[p*TW +: TW])
      );
   end

   assign fwd_vld  = fin_ok;
   assign fwd_tag  = fin_tag;
   assign fwd_areg = fin_areg;
   assign fwd_data = fin_data;
endmodule

// File: rtl/rnb_rename_buf_chk.sv
module rnb_rename_buf_chk #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned PORTS   = 2,
   parameter int unsigned TW      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               alloc_gnt,
   input logic [TW-1:0]      alloc_tag,
   input logic               wb_vld,
   input logic [TW-1:0]      wb_tag,
   input logic [ENTRIES-1:0] busy,
   input logic [ENTRIES-1:0] done,
   input logic [PORTS-1:0]   rd_ready,
   input logic [PORTS*TW-1:0] rd_tag,
   input logic               fwd_vld,
   input logic [TW-1:0]      fwd_tag
);
   logic wb_hit;
   assign wb_hit = wb_vld && busy[wb_tag] && done[wb_tag];

   assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> (busy == '0));

   assert_gnt_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> (!busy[alloc_tag] || (wb_hit && (wb_tag == alloc_tag))));

   assert_gnt_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |=> busy[$past(alloc_tag)]);

   assert_no_gnt_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((&busy) && !wb_hit) |-> !alloc_gnt);

   for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
      assert_wait_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_ready[p] |-> (busy[rd_tag[p*TW +: TW]] && !done[rd_tag[p*TW +: TW]]));
   end

   assert_fwd_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_vld && !flush) |=> done[$past(fwd_tag)]);

   assert_wb_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_hit && !flush && !(alloc_gnt && (alloc_tag == wb_tag))) |=> !busy[$past(wb_tag)]);

   assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (busy == '0));

   assert_fwd_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_vld |-> (busy[fwd_tag] && !done[fwd_tag]));
endmodule

bind rnb_rename_buf rnb_rename_buf_chk #(
   .ENTRIES (ENTRIES),
   .PORTS   (PORTS),
   .TW      (TW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .alloc_gnt (alloc_gnt),
   .alloc_tag (alloc_tag),
   .wb_vld    (wb_vld),
   .wb_tag    (wb_tag),
   .busy      (ent_busy),
   .done      (ent_done),
   .rd_ready  (rd_ready),
   .rd_tag    (rd_tag),
   .fwd_vld   (fwd_vld),
   .fwd_tag   (fwd_tag)
);

// File: tb/rnb_rename_buf_bench.sv
module rnb_rename_buf_bench;
   localparam int unsigned ENTRIES = 8;
   localparam int unsigned REGS    = 32;
   localparam int unsigned WIDTH   = 32;
   localparam int unsigned PORTS   = 2;
   localparam int unsigned TW      = $clog2(ENTRIES);
   localparam int unsigned AW      = $clog2(REGS);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     flush = 1'b0;
   logic                     alloc_req = 1'b0;
   logic [AW-1:0]            alloc_areg = '0;
   logic                     alloc_gnt;
   logic [TW-1:0]            alloc_tag;
   logic                     fin_vld = 1'b0;
   logic [TW-1:0]            fin_tag = '0;
   logic [WIDTH-1:0]         fin_data = '0;
   logic                     wb_vld = 1'b0;
   logic [TW-1:0]            wb_tag = '0;
   logic [PORTS*AW-1:0]      rd_areg = '0;
   logic [PORTS*WIDTH-1:0]   rd_data;
   logic [PORTS-1:0]         rd_ready;
   logic [PORTS*TW-1:0]      rd_tag;
   logic                     fwd_vld;
   logic [TW-1:0]            fwd_tag;
   logic [AW-1:0]            fwd_areg;
   logic [WIDTH-1:0]         fwd_data;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rnb_rename_buf #(
      .ENTRIES (ENTRIES),
      .REGS    (REGS),
      .WIDTH   (WIDTH),
      .PORTS   (PORTS)
   ) u_rnb_rename_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_req  (alloc_req),
      .alloc_areg (alloc_areg),
      .alloc_gnt  (alloc_gnt),
      .alloc_tag  (alloc_tag),
      .fin_vld    (fin_vld),
      .fin_tag    (fin_tag),
      .fin_data   (fin_data),
      .wb_vld     (wb_vld),
      .wb_tag     (wb_tag),
      .rd_areg    (rd_areg),
      .rd_data    (rd_data),
      .rd_ready   (rd_ready),
      .rd_tag     (rd_tag),
      .fwd_vld    (fwd_vld),
      .fwd_tag    (fwd_tag),
      .fwd_areg   (fwd_areg),
      .fwd_data   (fwd_data)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // commit the current cycle's inputs and return just after the edge
   task automatic step();
      @(posedge clk);
      #1;
      alloc_req = 1'b0;
      fin_vld   = 1'b0;
      wb_vld    = 1'b0;
      flush     = 1'b0;
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic set_rd(input int p, input int areg);
      rd_areg[p*AW +: AW] = AW'(areg);
   endtask

   task automatic expect_rd(input string req, input int p, input int areg,
                            input logic rdy, input logic [WIDTH-1:0] data,
                            input logic [TW-1:0] tag);
      set_rd(p, areg);
      settle();
      check(req, {63'd0, rd_ready[p]}, {63'd0, rdy});
      if (rdy) check(req, 64'(rd_data[p*WIDTH +: WIDTH]), 64'(data));
      else     check(req, 64'(rd_tag[p*TW +: TW]), 64'(tag));
   endtask

   task automatic do_alloc(input string req, input int areg, input int exp_tag);
      alloc_req  = 1'b1;
      alloc_areg = AW'(areg);
      settle();
      check(req, {63'd0, alloc_gnt}, 64'd1);
      check(req, 64'(alloc_tag), 64'(exp_tag));
      step();
   endtask

   task automatic do_fin(input int tag, input logic [WIDTH-1:0] data);
      fin_vld  = 1'b1;
      fin_tag  = TW'(tag);
      fin_data = data;
      step();
   endtask

   task automatic do_wb(input int tag);
      wb_vld = 1'b1;
      wb_tag = TW'(tag);
      step();
   endtask

   task automatic t_reset();
      // R1: empty buffer, zeroed registers
      expect_rd("R1", 0, 0, 1'b1, 32'h0, '0);
      expect_rd("R1", 1, 31, 1'b1, 32'h0, '0);
      check("R1", 64'(alloc_tag), 64'd0);
      check("R1", {63'd0, alloc_gnt}, 64'd0);
      check("R1", {63'd0, fwd_vld}, 64'd0);
   endtask

   task automatic t_commit();
      do_alloc("R2", 5, 0);
      do_fin(0, 32'h0000_00A5);
      wb_vld = 1'b1;
      wb_tag = '0;
      expect_rd("R7", 0, 5, 1'b1, 32'h0000_00A5, '0);
      step();
      expect_rd("R7", 0, 5, 1'b1, 32'h0000_00A5, '0);
      expect_rd("R3", 1, 5, 1'b1, 32'h0000_00A5, '0);
      check("R7", 64'(alloc_tag), 64'd0);
   endtask

   task automatic t_forward();
      do_alloc("R2", 7, 0);
      expect_rd("R4", 0, 7, 1'b0, '0, 3'd0);
      fin_vld  = 1'b1;
      fin_tag  = 3'd0;
      fin_data = 32'h0000_0077;
      set_rd(0, 5);
      expect_rd("R5", 1, 7, 1'b1, 32'h0000_0077, '0);
      expect_rd("R10", 0, 5, 1'b1, 32'h0000_00A5, '0);
      check("R12", {63'd0, fwd_vld}, 64'd1);
      check("R12", 64'(fwd_tag), 64'd0);
      check("R12", 64'(fwd_areg), 64'd7);
      check("R12", 64'(fwd_data), 64'h77);
      step();
      expect_rd("R6", 0, 7, 1'b1, 32'h0000_0077, '0);
      do_alloc("R2", 7, 1);
      expect_rd("R6", 0, 7, 1'b0, '0, 3'd1);
      do_fin(1, 32'h0000_0099);
      do_wb(0);
      expect_rd("R6", 0, 7, 1'b1, 32'h0000_0099, '0);
      do_wb(1);
      expect_rd("R7", 1, 7, 1'b1, 32'h0000_0099, '0);
      check("R7", 64'(alloc_tag), 64'd0);
   endtask

   task automatic t_ignore();
      fin_vld  = 1'b1;
      fin_tag  = 3'd3;
      fin_data = 32'hDEAD_BEEF;
      settle();
      check("R11", {63'd0, fwd_vld}, 64'd0);
      step();
      for (int i = 0; i < 4; i++) do_alloc("R2", 9 + i, i);
      expect_rd("R11", 0, 12, 1'b0, '0, 3'd3);
      do_wb(3);
      expect_rd("R11", 0, 12, 1'b0, '0, 3'd3);
      check("R11", 64'(alloc_tag), 64'd4);
   endtask

   task automatic t_full();
      for (int i = 4; i < 8; i++) do_alloc("R2", 9 + i, i);
      alloc_req  = 1'b1;
      alloc_areg = AW'(17);
      settle();
      check("R2", {63'd0, alloc_gnt}, 64'd0);
      step();
      do_fin(2, 32'h0000_0022);
      wb_vld     = 1'b1;
      wb_tag     = 3'd2;
      alloc_req  = 1'b1;
      alloc_areg = AW'(20);
      settle();
      check("R8", {63'd0, alloc_gnt}, 64'd1);
      check("R8", 64'(alloc_tag), 64'd2);
      step();
      expect_rd("R8", 0, 11, 1'b1, 32'h0000_0022, '0);
      expect_rd("R8", 1, 20, 1'b0, '0, 3'd2);
   endtask

   task automatic t_flush();
      do_fin(5, 32'h0000_0055);
      flush      = 1'b1;
      wb_vld     = 1'b1;
      wb_tag     = 3'd5;
      alloc_req  = 1'b1;
      alloc_areg = AW'(21);
      settle();
      check("R9", {63'd0, alloc_gnt}, 64'd0);
      step();
      expect_rd("R9", 0, 14, 1'b1, 32'h0000_0055, '0);
      expect_rd("R9", 1, 12, 1'b1, 32'h0, '0);
      expect_rd("R9", 0, 20, 1'b1, 32'h0, '0);
      expect_rd("R9", 1, 21, 1'b1, 32'h0, '0);
      check("R9", 64'(alloc_tag), 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_commit();
      t_forward();
      t_ignore();
      t_full();
      t_flush();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule